// File: doc/BRIEF.md
# Trap Vector Dispatch Unit

This block sits beside the fetch stage of a processor core and turns trap requests into a redirect. Each trap belongs to one of eight classes. Each class has its own handler slot of 32 bytes, placed above a base address that software writes. When a trap is taken, the block sends out three things: the handler address, the trap's 8-bit identifier zero-extended to 32 bits (to be loaded into general data register 15), and a one-cycle redirect strobe.

Requests arrive on two per-class request vectors. The synchronous vector carries traps tied to the instruction now executing, such as illegal opcodes, protection faults, system calls and assertion instructions. The asynchronous vector carries conditions signalled by hardware outside the core, such as bus or ECC errors and non-maskable interrupts. There is no enable and no mask. Every request is eventually taken. A request that loses arbitration waits in a per-class pending slot.

One trap is dispatched per cycle. The redirect comes one clock after the request is sampled. Synchronous traps win over asynchronous ones, and within a group the lowest class number wins.

Top module: `trap_dispatch`

## Requirements
- R1: After reset, redirect and d15_wr are 0, handler_addr, trap_class, trap_async and d15_data are 0, and base_out is 0.
- R2: A cycle with base_wr_en high loads base_wr_data into the base register with bits [4:0] forced to zero. The new value appears on base_out after the next clock edge.
- R3: handler_addr equals base + trap_class*32, where base is the base register value in the cycle the trap was selected. A base write in that same cycle affects only later traps.
- R4: d15_data carries the taken trap's 8-bit identifier in bits [7:0], with bits [31:8] zero. d15_wr is high in exactly the cycles redirect is high.
- R5: A request sampled at a clock edge, with nothing of higher priority pending, gives redirect high after that same edge. Each taken trap produces exactly one cycle of redirect.
- R6: When synchronous and asynchronous requests are present together, a synchronous one is taken first. trap_async is 0 for a synchronous trap and 1 for an asynchronous trap.
- R7: Within one group, the lowest class index among the requesting and pending classes is taken first. trap_class reports that index.
- R8: Requests that lose arbitration stay pending with their identifier. They are taken in priority order on following cycles, one per cycle, with no gap between them. Nothing can mask or discard them.
- R9: A new request to a class slot that is already pending in the same group is merged. The identifier captured first is the one delivered, and only one trap is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_req | input | 8 | Synchronous trap request, bit i = class i |
| sync_tin | input | 64 | Identifiers for synchronous requests, bits [8i+7:8i] for class i |
| async_req | input | 8 | Asynchronous trap request, bit i = class i |
| async_tin | input | 64 | Identifiers for asynchronous requests, bits [8i+7:8i] for class i |
| base_wr_en | input | 1 | Write strobe for the base register |
| base_wr_data | input | 32 | Value written to the base register |
| base_out | output | 32 | Current base register value |
| redirect | output | 1 | One-cycle fetch redirect strobe |
| handler_addr | output | 32 | Handler address for the taken trap |
| trap_class | output | 3 | Class of the taken trap |
| trap_async | output | 1 | Taken trap came from the asynchronous group |
| d15_wr | output | 1 | Write enable for data register 15 |
| d15_data | output | 32 | Zero-extended identifier for data register 15 |

## Verification
The bench sends requests from both groups in the same cycle. A design with the group priority reversed would redirect to the asynchronous handler first.

It also sends three synchronous classes at once. This exposes a priority encoder that favours the highest index, and pending logic that drops losers or leaves idle cycles between them.

Two further cases target the timing of stored state. A base write in the same cycle as a request catches an address computed from the new base too early. A repeated request to a class that is already pending catches a slot that overwrites its identifier or dispatches the same trap twice.

The identifier 0xFF checks that d15_data is zero-extended rather than sign-extended.

// File: rtl/trap_dispatch_pkg.sv
package trap_dispatch_pkg;
    localparam int unsigned TD_CLASSES = 8;
    localparam int unsigned TD_TIN_W   = 8;
    localparam int unsigned TD_ADDR_W  = 32;
    localparam int unsigned TD_SLOT_SH = 5;

    typedef enum logic {
        SRC_SYNC  = 1'b0,
        SRC_ASYNC = 1'b1
    } trap_src_e;
endpackage

// File: rtl/trap_prio_pick.sv
module trap_prio_pick #(
    parameter int unsigned N     = 8,
    localparam int unsigned IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/trap_pend_bank.sv
module trap_pend_bank #(
    parameter int unsigned N     = 8,
    parameter int unsigned TIN_W = 8,
    localparam int unsigned IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    input  logic [N*TIN_W-1:0] tin_in,
    input  logic             take,
    output logic             any,
    output logic [IW-1:0]    win_idx,
    output logic [TIN_W-1:0] win_tin
);
    typedef struct packed {
        logic [N-1:0]            pend;
        logic [N-1:0][TIN_W-1:0] tin;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [N-1:0]            eff;
    logic [N-1:0][TIN_W-1:0] eff_tin;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_slot
            assign eff[g]     = bank_q.pend[g] | req[g];
            assign eff_tin[g] = bank_q.pend[g] ? bank_q.tin[g]
                                               : tin_in[g*TIN_W +: TIN_W];
        end
    endgenerate

    trap_prio_pick #(.N(N)) u_pick (
        .req (eff),
        .any (any),
        .idx (win_idx)
    );

    assign win_tin = eff_tin[win_idx];

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < N; i++) begin
            if (eff[i] && !(take && (win_idx == IW'(i)))) begin
                bank_d.pend[i] = 1'b1;
                bank_d.tin[i]  = eff_tin[i];
            end else begin
                bank_d.pend[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end
endmodule

// File: rtl/trap_vec_calc.sv
module trap_vec_calc #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned CLS_W   = 3,
    parameter int unsigned SLOT_SH = 5
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CLS_W-1:0]  cls,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] offset;
    always_comb begin
        offset = ADDR_W'(cls) << SLOT_SH;
        addr   = base + offset;
    end
endmodule

// File: rtl/trap_dispatch.sv
module trap_dispatch
    import trap_dispatch_pkg::*;
#(
    parameter int unsigned NUM_CLASSES = TD_CLASSES,
    parameter int unsigned TIN_W       = TD_TIN_W,
    parameter int unsigned ADDR_W      = TD_ADDR_W,
    parameter int unsigned SLOT_SH     = TD_SLOT_SH,
    localparam int unsigned CLS_W      = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CLASSES-1:0]     sync_req,
    input  logic [NUM_CLASSES*TIN_W-1:0] sync_tin,
    input  logic [NUM_CLASSES-1:0]     async_req,
    input  logic [NUM_CLASSES*TIN_W-1:0] async_tin,
    input  logic                       base_wr_en,
    input  logic [ADDR_W-1:0]          base_wr_data,
    output logic [ADDR_W-1:0]          base_out,
    output logic                       redirect,
    output logic [ADDR_W-1:0]          handler_addr,
    output logic [CLS_W-1:0]           trap_class,
    output logic                       trap_async,
    output logic                       d15_wr,
    output logic [ADDR_W-1:0]          d15_data
);
    localparam logic [ADDR_W-1:0] BASE_MASK = ~((ADDR_W'(1) << SLOT_SH) - ADDR_W'(1));

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic              redirect;
        logic [ADDR_W-1:0] addr;
        logic [CLS_W-1:0]  cls;
        trap_src_e         src;
        logic [TIN_W-1:0]  tin;
    } disp_t;

    disp_t st_d, st_q;

    logic             s_any, a_any;
    logic [CLS_W-1:0] s_idx, a_idx;
    logic [TIN_W-1:0] s_tin, a_tin;
    logic             take_s, take_a;
    logic [CLS_W-1:0] sel_cls;
    logic [ADDR_W-1:0] sel_addr;

    assign take_s = s_any;
    assign take_a = a_any & ~s_any;

    trap_pend_bank #(.N(NUM_CLASSES), .TIN_W(TIN_W)) u_sync_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (sync_req),
        .tin_in  (sync_tin),
        .take    (take_s),
        .any     (s_any),
        .win_idx (s_idx),
        .win_tin (s_tin)
    );

    trap_pend_bank #(.N(NUM_CLASSES), .TIN_W(TIN_W)) u_async_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (async_req),
        .tin_in  (async_tin),
        .take    (take_a),
        .any     (a_any),
        .win_idx (a_idx),
        .win_tin (a_tin)
    );

    assign sel_cls = take_s ? s_idx : a_idx;

    trap_vec_calc #(.ADDR_W(ADDR_W), .CLS_W(CLS_W), .SLOT_SH(SLOT_SH)) u_vec (
        .base (st_q.base),
        .cls  (sel_cls),
        .addr (sel_addr)
    );

    always_comb begin
        st_d          = st_q;
        st_d.redirect = take_s | take_a;
        if (base_wr_en) st_d.base = base_wr_data & BASE_MASK;
        if (take_s | take_a) begin
            st_d.addr = sel_addr;
            st_d.cls  = sel_cls;
            st_d.src  = take_s ? SRC_SYNC : SRC_ASYNC;
            st_d.tin  = take_s ? s_tin : a_tin;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_out     = st_q.base;
    assign redirect     = st_q.redirect;
    assign handler_addr = st_q.addr;
    assign trap_class   = st_q.cls;
    assign trap_async   = (st_q.src == SRC_ASYNC);
    assign d15_wr       = st_q.redirect;
    assign d15_data     = ADDR_W'(st_q.tin);
endmodule

// File: rtl/trap_dispatch_chk.sv
module trap_dispatch_chk #(
    parameter int unsigned NUM_CLASSES = 8,
    parameter int unsigned TIN_W       = 8,
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned SLOT_SH     = 5,
    localparam int unsigned CLS_W      = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_CLASSES-1:0] sync_req,
    input logic [NUM_CLASSES-1:0] async_req,
    input logic                   base_wr_en,
    input logic [ADDR_W-1:0]      base_wr_data,
    input logic [ADDR_W-1:0]      base_out,
    input logic                   redirect,
    input logic [ADDR_W-1:0]      handler_addr,
    input logic [CLS_W-1:0]       trap_class,
    input logic                   trap_async,
    input logic                   d15_wr,
    input logic [ADDR_W-1:0]      d15_data
);
    localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << SLOT_SH) - ADDR_W'(1);

    a_r2_base_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (base_out & LOW_MASK) == '0);

    a_r2_base_loads: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr_en |=> base_out == ($past(base_wr_data) & ~LOW_MASK));

    a_r3_addr_from_base: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (handler_addr - $past(base_out)) == (ADDR_W'(trap_class) << SLOT_SH));

    a_r4_d15_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        d15_wr |-> (d15_data >> TIN_W) == '0);

    a_r5_request_redirects: assert property (@(posedge clk) disable iff (!rst_n)
        ((sync_req != '0) || (async_req != '0)) |=> redirect);

    a_r6_sync_first: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_req != '0) |=> (redirect && !trap_async));
endmodule

bind trap_dispatch trap_dispatch_chk #(
    .NUM_CLASSES (NUM_CLASSES),
    .TIN_W       (TIN_W),
    .ADDR_W      (ADDR_W),
    .SLOT_SH     (SLOT_SH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_req     (sync_req),
    .async_req    (async_req),
    .base_wr_en   (base_wr_en),
    .base_wr_data (base_wr_data),
    .base_out     (base_out),
    .redirect     (redirect),
    .handler_addr (handler_addr),
    .trap_class   (trap_class),
    .trap_async   (trap_async),
    .d15_wr       (d15_wr),
    .d15_data     (d15_data)
);

// File: tb/trap_dispatch_test.sv
module trap_dispatch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sync_req = '0;
    logic [63:0] sync_tin = '0;
    logic [7:0]  async_req = '0;
    logic [63:0] async_tin = '0;
    logic        base_wr_en = 1'b0;
    logic [31:0] base_wr_data = '0;
    logic [31:0] base_out, handler_addr, d15_data;
    logic        redirect, trap_async, d15_wr;
    logic [2:0]  trap_class;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    trap_dispatch uut (
        .clk(clk), .rst_n(rst_n),
        .sync_req(sync_req), .sync_tin(sync_tin),
        .async_req(async_req), .async_tin(async_tin),
        .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
        .base_out(base_out), .redirect(redirect), .handler_addr(handler_addr),
        .trap_class(trap_class), .trap_async(trap_async),
        .d15_wr(d15_wr), .d15_data(d15_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        sync_req = '0; async_req = '0; base_wr_en = 1'b0;
    endtask

    task automatic expect_trap(input string req, input logic [31:0] addr,
                               input logic [2:0] cls, input logic asy, input logic [7:0] tin);
        chk({req, " redirect"}, {31'd0, redirect}, 32'd1);
        chk({req, " d15_wr"},   {31'd0, d15_wr},   32'd1);
        chk({req, " addr"},     handler_addr, addr);
        chk({req, " class"},    {29'd0, trap_class}, {29'd0, cls});
        chk({req, " async"},    {31'd0, trap_async}, {31'd0, asy});
        chk({req, " d15"},      d15_data, {24'd0, tin});
    endtask

    task automatic expect_idle(input string req);
        chk({req, " no redirect"}, {30'd0, redirect, d15_wr}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 redirect", {30'd0, redirect, d15_wr}, 32'd0);
        chk("R1 base", base_out, 32'd0);
        chk("R1 addr", handler_addr, 32'd0);
        chk("R1 d15", d15_data, 32'd0);
        chk("R1 class/async", {28'd0, trap_class, trap_async}, 32'd0);
    endtask

    task automatic t_base_write();
        base_wr_en = 1'b1; base_wr_data = 32'h8000_00FF;
        step();
        chk("R2 base low bits cleared", base_out, 32'h8000_00E0);
        expect_idle("R2");
    endtask

    task automatic t_single_sync();
        sync_req[3] = 1'b1; sync_tin[3*8 +: 8] = 8'h5A;
        step();
        expect_trap("R3 R4 R5 sync class3", 32'h8000_0140, 3'd3, 1'b0, 8'h5A);
        step();
        expect_idle("R5 single pulse");
    endtask

    task automatic t_single_async();
        async_req[6] = 1'b1; async_tin[6*8 +: 8] = 8'hC3;
        step();
        expect_trap("R6 async class6", 32'h8000_01A0, 3'd6, 1'b1, 8'hC3);
        step();
        expect_idle("R5 async pulse");
    endtask

    task automatic t_group_prio();
        sync_req[2] = 1'b1; sync_tin[2*8 +: 8] = 8'h22;
        async_req[0] = 1'b1; async_tin[0 +: 8] = 8'h10;
        step();
        expect_trap("R6 sync before async", 32'h8000_0120, 3'd2, 1'b0, 8'h22);
        step();
        expect_trap("R8 async held", 32'h8000_00E0, 3'd0, 1'b1, 8'h10);
        step();
        expect_idle("R8 drained");
    endtask

    task automatic t_class_prio();
        sync_req[5] = 1'b1; sync_tin[5*8 +: 8] = 8'h55;
        sync_req[1] = 1'b1; sync_tin[1*8 +: 8] = 8'h11;
        sync_req[7] = 1'b1; sync_tin[7*8 +: 8] = 8'h77;
        step();
        expect_trap("R7 class1 first", 32'h8000_0100, 3'd1, 1'b0, 8'h11);
        step();
        expect_trap("R8 class5 next", 32'h8000_0180, 3'd5, 1'b0, 8'h55);
        step();
        expect_trap("R8 class7 last", 32'h8000_01C0, 3'd7, 1'b0, 8'h77);
        step();
        expect_idle("R8 queue empty");
    endtask

    task automatic t_merge();
        sync_req[0] = 1'b1; sync_tin[0 +: 8] = 8'hA0;
        async_req[4] = 1'b1; async_tin[4*8 +: 8] = 8'h11;
        step();
        expect_trap("R9 sync0", 32'h8000_00E0, 3'd0, 1'b0, 8'hA0);
        sync_req[1] = 1'b1; sync_tin[1*8 +: 8] = 8'h33;
        async_req[4] = 1'b1; async_tin[4*8 +: 8] = 8'h22;
        step();
        expect_trap("R9 sync1", 32'h8000_0100, 3'd1, 1'b0, 8'h33);
        step();
        expect_trap("R9 first identifier kept", 32'h8000_0160, 3'd4, 1'b1, 8'h11);
        step();
        expect_idle("R9 merged single trap");
    endtask

    task automatic t_base_race();
        base_wr_en = 1'b1; base_wr_data = 32'h1000_0000;
        sync_req[7] = 1'b1; sync_tin[7*8 +: 8] = 8'hFF;
        step();
        expect_trap("R3 old base used, R4 zero-ext", 32'h8000_01C0, 3'd7, 1'b0, 8'hFF);
        chk("R2 new base", base_out, 32'h1000_0000);
        async_req[2] = 1'b1; async_tin[2*8 +: 8] = 8'h80;
        step();
        expect_trap("R3 new base", 32'h1000_0040, 3'd2, 1'b1, 8'h80);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_base_write();
        t_single_sync();
        t_single_async();
        t_group_prio();
        t_class_prio();
        t_merge();
        t_base_race();
        step();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule